// File: doc/BRIEF.md
# Indexed Word Load/Store Address Unit

This unit turns one word transfer request into a memory access and a base register update. A request carries a base value, an offset and two selects. The offset is either a small unsigned immediate byte count or the full value of an index register. One select picks load or store. The other picks the indexing mode. In offset mode the base is left unchanged. In pre-indexed mode the access goes to base plus offset and that sum becomes the new base. In post-indexed mode the access goes to the untouched base and the sum becomes the new base afterwards.

Every accepted request is checked before it reaches memory. An address that is not on a four-byte boundary, or that lies outside the usable RAM window, ends the request with a fault. A faulted request never reaches memory and never updates the base. A good request drives one request pulse on a word memory port with a one-cycle response. It then reports completion together with the load data and the base writeback.

Top module: `ldst_addr_unit`

## Requirements
- R1: Mode code 0 (offset) accesses base+offset, and base_wb_en stays low for the whole request.
- R2: With op_use_index=1 the offset is op_index. With op_use_index=0 it is op_imm, zero-extended.
- R3: Mode code 1 (pre-indexed) accesses base+offset and completes with base_wb_en=1 and base_wb_value=base+offset.
- R4: Mode code 2 (post-indexed) accesses the unmodified base and completes with base_wb_en=1 and base_wb_value=base+offset.
- R5: A load (op_store=0) drives mem_we=0 and returns the read word on ld_data in the cycle done is high.
- R6: A store (op_store=1) drives mem_we=1 and mem_wdata=op_wdata, with the same address rules as a load. A later load from that address returns the stored word.
- R7: An access address with bit 1 or bit 0 set completes with done=1 and fault=1. It issues no memory request and leaves base_wb_en low.
- R8: An access address below 0x40000000, or at or above 0x40000000+WIN_BYTES (default 0x40010000), faults in the same way. The top word 0x4000FFFC is allowed.
- R9: Each good request gives exactly one single-cycle mem_req. done is a one-cycle pulse in the cycle after mem_rvalid, and base_wb_en is only ever high together with done. op_ready is low from acceptance until done.
- R10: After reset op_ready=1, and done, fault, mem_req and base_wb_en are 0.
- R11: Mode code 3 behaves as offset mode: it accesses base+offset with no writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Request strobe, taken while op_ready is high |
| op_ready | output | 1 | Unit idle and able to take a request |
| op_store | input | 1 | 1 = store, 0 = load |
| op_mode | input | 2 | 0 offset, 1 pre-indexed, 2 post-indexed, 3 as offset |
| op_use_index | input | 1 | Offset source: 1 = op_index, 0 = op_imm |
| op_imm | input | IMM_W | Immediate byte offset, unsigned |
| op_index | input | AW | Index register value |
| op_base | input | AW | Base register value |
| op_wdata | input | DW | Store data |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Write enable qualifying mem_req |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | DW | Write word |
| mem_rvalid | input | 1 | Response, one cycle after mem_req |
| mem_rdata | input | DW | Read word valid with mem_rvalid |
| done | output | 1 | Request complete (pulse) |
| fault | output | 1 | Request ended by an alignment or window fault |
| ld_data | output | DW | Loaded word, 0 for stores and faults |
| base_wb_en | output | 1 | Write base_wb_value into the base register |
| base_wb_value | output | AW | New base value |

## Verification
The assertions assume that the memory answers each mem_req with exactly one mem_rvalid in the following cycle, and never raises mem_rvalid on its own. They also assume op_valid is raised only while op_ready is high. The bench's memory model is a registered array that sets rvalid only on the edge after a request. The bench raises op_valid only from an idle unit, for a single cycle, and waits for done before the next request. The bench's own checks compare the observed address, the request count, the writeback and the data with values it computes from the requirements.

// File: rtl/ldst_pkg.sv
// Package: shared widths, mode codes and sequencer states for the
// load/store address unit. Assumes byte addressing of 32-bit words.
package ldst_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        MODE_OFFSET = 2'd0,
        MODE_PRE    = 2'd1,
        MODE_POST   = 2'd2,
        MODE_RSVD   = 2'd3
    } idx_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ldst_ea_calc.sv
// Effective address calculator. Picks the offset source, forms base+offset
// and chooses the access address and writeback request from the mode.
// Purely combinational; the sum wraps modulo 2**AW.
module ldst_ea_calc
    import ldst_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IMM_W = 12
) (
    input  logic [AW-1:0]    base,
    input  logic             use_index,
    input  logic [IMM_W-1:0] imm,
    input  logic [AW-1:0]    index,
    input  logic [1:0]       mode,
    output logic [AW-1:0]    acc_addr,
    output logic [AW-1:0]    wb_value,
    output logic             wb_req
);
    localparam int PAD_W = AW - IMM_W;

    logic [AW-1:0] offset;
    logic [AW-1:0] sum;

    // Offset source select and address sum.
    always_comb begin
        offset = use_index ? index : {{PAD_W{1'b0}}, imm};
        sum    = base + offset;
    end

    // Mode decode: which address is accessed and whether the base moves.
    always_comb begin
        wb_value = sum;
        unique case (idx_mode_e'(mode))
            MODE_PRE: begin
                acc_addr = sum;
                wb_req   = 1'b1;
            end
            MODE_POST: begin
                acc_addr = base;
                wb_req   = 1'b1;
            end
            default: begin
                acc_addr = sum;
                wb_req   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ldst_access_check.sv
// Access legality check: word alignment and, when CHECK_WINDOW is set,
// membership in the RAM window [WIN_BASE, WIN_BASE+WIN_BYTES).
// Assumes WIN_BASE+WIN_BYTES does not wrap past 2**AW.
module ldst_access_check #(
    parameter int          AW           = 32,
    parameter int          ALIGN_BITS   = 2,
    parameter bit          CHECK_WINDOW = 1'b1,
    parameter logic [31:0] WIN_BASE     = 32'h4000_0000,
    parameter logic [31:0] WIN_BYTES    = 32'h0001_0000
) (
    input  logic [AW-1:0] addr,
    output logic          fault
);
    logic misaligned;
    logic outside;

    // Any low address bit set means the word is not on its boundary.
    always_comb misaligned = |addr[ALIGN_BITS-1:0];

    generate
        if (CHECK_WINDOW) begin : g_window
            logic [AW-1:0] rel;
            // Window test via distance from the window start.
            always_comb begin
                rel     = addr - AW'(WIN_BASE);
                outside = (addr < AW'(WIN_BASE)) || (rel >= AW'(WIN_BYTES));
            end
        end else begin : g_nowindow
            // Window check disabled: every aligned address is legal.
            always_comb outside = 1'b0;
        end
    endgenerate

    // Combined fault.
    always_comb fault = misaligned | outside;
endmodule

// File: rtl/ldst_seq.sv
// Request sequencer: latches an accepted request, issues one memory request
// unless the request faulted, waits for the one-cycle response and reports
// completion, load data and base writeback together.
// Assumes the memory returns exactly one rvalid per request.
module ldst_seq
    import ldst_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          DW        = 32,
    parameter logic [31:0] WIN_BASE  = 32'h4000_0000,
    parameter logic [31:0] WIN_BYTES = 32'h0001_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    output logic          op_ready,
    input  logic          op_store,
    input  logic [AW-1:0] acc_addr,
    input  logic [AW-1:0] wb_value,
    input  logic          wb_req,
    input  logic          chk_fault,
    input  logic [DW-1:0] op_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          done,
    output logic          fault,
    output logic [DW-1:0] ld_data,
    output logic          base_wb_en,
    output logic [AW-1:0] base_wb_value
);
    seq_state_e    state;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] wbv_q;
    logic [DW-1:0] wdata_q;
    logic          wbreq_q;
    logic          store_q;
    logic          fault_q;

    // Handshake and memory port outputs from the held request.
    always_comb begin
        op_ready  = (state == ST_IDLE);
        mem_req   = (state == ST_ISSUE) && !fault_q;
        mem_we    = store_q;
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
    end

    // Sequencer state and request latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            wbv_q   <= '0;
            wdata_q <= '0;
            wbreq_q <= 1'b0;
            store_q <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (op_valid) begin
                    state   <= ST_ISSUE;
                    addr_q  <= acc_addr;
                    wbv_q   <= wb_value;
                    wdata_q <= op_wdata;
                    wbreq_q <= wb_req;
                    store_q <= op_store;
                    fault_q <= chk_fault;
                end
                ST_ISSUE: state <= fault_q ? ST_IDLE : ST_WAIT;
                ST_WAIT:  if (mem_rvalid) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Completion report: done pulse, fault, load data and writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done          <= 1'b0;
            fault         <= 1'b0;
            ld_data       <= '0;
            base_wb_en    <= 1'b0;
            base_wb_value <= '0;
        end else begin
            done       <= 1'b0;
            fault      <= 1'b0;
            base_wb_en <= 1'b0;
            if (state == ST_ISSUE && fault_q) begin
                done    <= 1'b1;
                fault   <= 1'b1;
                ld_data <= '0;
            end else if (state == ST_WAIT && mem_rvalid) begin
                done          <= 1'b1;
                ld_data       <= store_q ? '0 : mem_rdata;
                base_wb_en    <= wbreq_q;
                base_wb_value <= wbv_q;
            end
        end
    end

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R7
    AST_REQ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr >= AW'(WIN_BASE) && mem_addr - AW'(WIN_BASE) < AW'(WIN_BYTES))); // R8
    AST_FAULT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !base_wb_en); // R7
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_WB_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        base_wb_en |-> done); // R9
    AST_BUSY_DURING_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !op_ready); // R9
endmodule

// File: rtl/ldst_addr_unit.sv
// Top: indexed word load/store address unit. Connects the address
// calculator, the legality check and the request sequencer.
// Assumes op_valid is raised only while op_ready is high.
module ldst_addr_unit
    import ldst_pkg::*;
#(
    parameter int          AW        = ADDR_W,
    parameter int          DW        = DATA_W,
    parameter int          IMM_W     = 12,
    parameter logic [31:0] WIN_BASE  = 32'h4000_0000,
    parameter logic [31:0] WIN_BYTES = 32'h0001_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    output logic             op_ready,
    input  logic             op_store,
    input  logic [1:0]       op_mode,
    input  logic             op_use_index,
    input  logic [IMM_W-1:0] op_imm,
    input  logic [AW-1:0]    op_index,
    input  logic [AW-1:0]    op_base,
    input  logic [DW-1:0]    op_wdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_rvalid,
    input  logic [DW-1:0]    mem_rdata,
    output logic             done,
    output logic             fault,
    output logic [DW-1:0]    ld_data,
    output logic             base_wb_en,
    output logic [AW-1:0]    base_wb_value
);
    localparam int ALIGN_BITS = $clog2(DW / 8);

    logic [AW-1:0] acc_addr;
    logic [AW-1:0] wb_value;
    logic          wb_req;
    logic          chk_fault;

    ldst_ea_calc #(.AW(AW), .IMM_W(IMM_W)) u_ea (
        .base      (op_base),
        .use_index (op_use_index),
        .imm       (op_imm),
        .index     (op_index),
        .mode      (op_mode),
        .acc_addr  (acc_addr),
        .wb_value  (wb_value),
        .wb_req    (wb_req)
    );

    ldst_access_check #(
        .AW(AW), .ALIGN_BITS(ALIGN_BITS), .CHECK_WINDOW(1'b1),
        .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)
    ) u_chk (
        .addr  (acc_addr),
        .fault (chk_fault)
    );

    ldst_seq #(.AW(AW), .DW(DW), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_valid      (op_valid),
        .op_ready      (op_ready),
        .op_store      (op_store),
        .acc_addr      (acc_addr),
        .wb_value      (wb_value),
        .wb_req        (wb_req),
        .chk_fault     (chk_fault),
        .op_wdata      (op_wdata),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata),
        .done          (done),
        .fault         (fault),
        .ld_data       (ld_data),
        .base_wb_en    (base_wb_en),
        .base_wb_value (base_wb_value)
    );
endmodule

// File: tb/ldst_addr_unit_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module ldst_addr_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_ready;
    logic        op_store = 1'b0;
    logic [1:0]  op_mode = 2'd0;
    logic        op_use_index = 1'b0;
    logic [11:0] op_imm = '0;
    logic [31:0] op_index = '0;
    logic [31:0] op_base = '0;
    logic [31:0] op_wdata = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done, fault, base_wb_en;
    logic [31:0] ld_data, base_wb_value;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ldst_addr_unit u_ldst_addr_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_store(op_store), .op_mode(op_mode), .op_use_index(op_use_index),
        .op_imm(op_imm), .op_index(op_index), .op_base(op_base), .op_wdata(op_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done), .fault(fault),
        .ld_data(ld_data), .base_wb_en(base_wb_en), .base_wb_value(base_wb_value)
    );

    // Memory model: 256 words, one-cycle registered response.
    logic [31:0] mem [256];
    int          req_cnt = 0;
    logic [31:0] last_addr = '0;
    logic        last_we = 1'b0;
    logic        wb_seen = 1'b0;
    initial for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 + i;
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (base_wb_en && !done) wb_seen <= 1'b1;
        if (mem_req) begin
            req_cnt   <= req_cnt + 1;
            last_addr <= mem_addr;
            last_we   <= mem_we;
            mem_rvalid <= 1'b1;
            mem_rdata <= mem[mem_addr[9:2]];
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Result of the last request.
    logic        r_fault, r_wb;
    logic [31:0] r_wbv, r_ld;
    int          r_reqs;
    logic        r_busy;

    task automatic run(input logic st, input logic [1:0] md, input logic ui,
                       input logic [11:0] im, input logic [31:0] ix,
                       input logic [31:0] bs, input logic [31:0] wd);
        int c0;
        int n;
        @(negedge clk);
        op_store = st; op_mode = md; op_use_index = ui; op_imm = im;
        op_index = ix; op_base = bs; op_wdata = wd; op_valid = 1'b1;
        c0 = req_cnt;
        @(negedge clk);
        op_valid = 1'b0;
        r_busy = !op_ready;
        n = 0;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            errors++;
            $display("FAIL R9 done never seen actual=0 expected=1");
        end
        r_fault = fault; r_wb = base_wb_en; r_wbv = base_wb_value; r_ld = ld_data;
        @(negedge clk);
        r_reqs = req_cnt - c0;
    endtask

    task automatic t_reset();
        chk("R10 ready", {31'd0, op_ready}, 32'd1);
        chk("R10 done", {31'd0, done}, 32'd0);
        chk("R10 fault", {31'd0, fault}, 32'd0);
        chk("R10 mem_req", {31'd0, mem_req}, 32'd0);
        chk("R10 wb_en", {31'd0, base_wb_en}, 32'd0);
    endtask

    task automatic t_offset_imm();
        wb_seen = 1'b0;
        run(1'b0, 2'd0, 1'b0, 12'h004, 32'hFFFF_FFFF, 32'h4000_0000, '0);
        chk("R1 addr", last_addr, 32'h4000_0004);
        chk("R2 imm offset", last_addr, 32'h4000_0004);
        chk("R1 no wb", {31'd0, r_wb | wb_seen}, 32'd0);
        chk("R5 load data", r_ld, 32'hA500_0001);
        chk("R5 we", {31'd0, last_we}, 32'd0);
        chk("R9 one req", r_reqs, 1);
        chk("R9 busy", {31'd0, r_busy}, 32'd1);
    endtask

    task automatic t_offset_index();
        run(1'b0, 2'd0, 1'b1, 12'hFFF, 32'h0000_0010, 32'h4000_0000, '0);
        chk("R2 index offset", last_addr, 32'h4000_0010);
        chk("R5 load data", r_ld, 32'hA500_0004);
    endtask

    task automatic t_pre();
        run(1'b0, 2'd1, 1'b0, 12'h010, '0, 32'h4000_0000, '0);
        chk("R3 addr", last_addr, 32'h4000_0010);
        chk("R3 wb_en", {31'd0, r_wb}, 32'd1);
        chk("R3 wb value", r_wbv, 32'h4000_0010);
    endtask

    task automatic t_post();
        run(1'b0, 2'd2, 1'b0, 12'h012, '0, 32'h4000_0000, '0);
        chk("R4 addr", last_addr, 32'h4000_0000);
        chk("R4 wb_en", {31'd0, r_wb}, 32'd1);
        chk("R4 wb value", r_wbv, 32'h4000_0012);
        chk("R4 data", r_ld, 32'hA500_0000);
    endtask

    task automatic t_misaligned();
        wb_seen = 1'b0;
        run(1'b0, 2'd1, 1'b0, 12'h012, '0, 32'h4000_0000, '0);
        chk("R7 fault bit1", {31'd0, r_fault}, 32'd1);
        chk("R7 no req", r_reqs, 0);
        chk("R7 no wb", {31'd0, r_wb | wb_seen}, 32'd0);
        run(1'b1, 2'd0, 1'b1, '0, 32'h0000_0021, 32'h4000_0000, 32'hDEAD_BEEF);
        chk("R7 fault bit0", {31'd0, r_fault}, 32'd1);
        chk("R7 store no req", r_reqs, 0);
        run(1'b0, 2'd0, 1'b0, 12'h020, '0, 32'h4000_0000, '0);
        chk("R7 memory untouched", r_ld, 32'hA500_0008);
    endtask

    task automatic t_window();
        run(1'b0, 2'd0, 1'b0, '0, '0, 32'h4000_FFFC, '0);
        chk("R8 top word ok", {31'd0, r_fault}, 32'd0);
        chk("R8 top word req", r_reqs, 1);
        run(1'b0, 2'd2, 1'b0, 12'h004, '0, 32'h4001_0000, '0);
        chk("R8 above fault", {31'd0, r_fault}, 32'd1);
        chk("R8 above no req", r_reqs, 0);
        chk("R8 above no wb", {31'd0, r_wb}, 32'd0);
        run(1'b0, 2'd0, 1'b1, '0, 32'h0000_0004, 32'h3FFF_FFF8, '0);
        chk("R8 below fault", {31'd0, r_fault}, 32'd1);
    endtask

    task automatic t_store();
        run(1'b1, 2'd1, 1'b0, 12'h040, '0, 32'h4000_0000, 32'h1234_5678);
        chk("R6 addr", last_addr, 32'h4000_0040);
        chk("R6 we", {31'd0, last_we}, 32'd1);
        chk("R6 wb", r_wbv, 32'h4000_0040);
        chk("R6 store ld_data zero", r_ld, 32'd0);
        run(1'b0, 2'd0, 1'b1, '0, 32'h0000_0040, 32'h4000_0000, '0);
        chk("R6 readback", r_ld, 32'h1234_5678);
    endtask

    task automatic t_mode3();
        wb_seen = 1'b0;
        run(1'b0, 2'd3, 1'b0, 12'h00C, '0, 32'h4000_0000, '0);
        chk("R11 addr", last_addr, 32'h4000_000C);
        chk("R11 no wb", {31'd0, r_wb | wb_seen}, 32'd0);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_offset_imm();
        t_offset_index();
        t_pre();
        t_post();
        t_misaligned();
        t_window();
        t_store();
        t_mode3();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule